// File: doc/BRIEF.md
# Pointer-Table Cell Scheduler for Structured TDM Segmentation

This block decides, once per TDM frame and for one port, which virtual circuits have gathered enough TDM bytes to fill a cell. It walks a per-port table held in a shared word-addressed memory. Each table entry points to one circuit's segmentation control structure. For each enabled entry the block reads that circuit's circular-buffer read pointer and compares it with the port's TDM write pointer. When at least one full cell payload is waiting, it raises a request to the cell assembler that carries the control-structure address. Once the request is accepted, the block moves the read pointer past one payload and writes it back.

A frame strobe starts the walk. Software chooses where the table sits, builds a chain of up to 32 entries and marks the last one. It may give circuits different starting read pointers so that cells for many lightly loaded circuits come due in different frames instead of all in the same frame. If a strobe arrives while a walk is still running, that strobe is counted as an overrun, and a fresh walk begins as soon as the current one ends.

Top module: `sdt_seg_sched`

## Requirements
- R1: After reset, `busy`, `cell_valid`, `mem_req`, `mem_we` and `ovr_pulse` are low and `ovr_count` is zero.
- R2: Table entry k is read from word address {`tbl_base`[13:5], k[4:0]}, so the low five bits of `tbl_base` have no effect. An entry word has the enable flag in bit 15, the last-entry flag in bit 14 and the control-structure word address in bits 13:0.
- R3: The walk visits entries in ascending order and ends after the first entry whose bit 14 is set, or after entry 31 if none is set. No word beyond that entry is read.
- R4: An entry with bit 15 clear causes no read or write of its control structure and raises no request.
- R5: Bits 7:0 of control-structure word 0 hold the read pointer. A circuit is due when (`wr_ptr` − read pointer) mod 256 is 47 or more. A due circuit raises `cell_valid`, with `cell_addr` equal to the control-structure address.
- R6: A circuit whose difference is 46 or less raises no request, and its control structure is not written.
- R7: After a request is accepted, word 0 of that control structure is written once. Bits 7:0 become (read pointer + 47) mod 256 and bits 15:8 are kept.
- R8: While `cell_valid` is high and `cell_ready` is low, `cell_valid` stays high, `cell_addr` is held and the walk does not advance.
- R9: A `frame_start` seen while a walk is running pulses `ovr_pulse` and adds one to `ovr_count`, which saturates. Exactly one further walk then follows without a gap.
- R10: Circuits whose starting read pointers are 0, 1, … 31, with the write pointer advancing by one per frame, come due in 32 different frames, at most one request per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at each TDM frame |
| wr_ptr | input | 8 | Current TDM write pointer into the circular buffers |
| tbl_base | input | 14 | Word address of the port's pointer table (low 5 bits ignored) |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable (read when low) |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after a read |
| cell_valid | output | 1 | Cell-build request valid |
| cell_ready | input | 1 | Cell-build request accepted |
| cell_addr | output | 14 | Control-structure address of the due circuit |
| busy | output | 1 | A table walk is in progress |
| ovr_pulse | output | 1 | One-cycle flag for an overrun frame strobe |
| ovr_count | output | 8 | Saturating count of overrun frame strobes |

## Verification
Assertions check on every cycle the properties that hold at each edge. A stalled request keeps its valid and address. Write-back happens only in the cycle after an accepted handshake. An idle block makes no memory access and no request. An overrun strobe raises the flag and advances the counter. The bench scenarios cover the behaviour that needs whole walks to show: the order and set of requests, the read and write traffic, the aligned table base, the end of the chain at the last-entry flag or at entry 31, modulo wrap of the pointers, the extra walk after an overrun, and the spreading of requests across frames by staggered offsets.

// File: rtl/sdt_sched_pkg.sv
package sdt_sched_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ENT_RD,
      ST_ENT_CAP,
      ST_CS_RD,
      ST_CS_CAP,
      ST_CHK,
      ST_REQ,
      ST_WB,
      ST_NEXT
   } walk_state_t;

endpackage

// File: rtl/sdt_due_calc.sv
module sdt_due_calc #(
   parameter int PTR_W   = 8,
   parameter int PAYLOAD = 47
) (
   input  logic [PTR_W-1:0] rd_ptr,
   input  logic [PTR_W-1:0] wr_ptr,
   output logic             due,
   output logic [PTR_W-1:0] rd_ptr_adv
);

   localparam logic [PTR_W-1:0] STEP = PTR_W'(PAYLOAD);

   if (PAYLOAD < 1 || PAYLOAD >= (1 << PTR_W)) begin : g_bad_payload
      $error("sdt_due_calc: PAYLOAD must fit in the pointer range");
   end

   logic [PTR_W-1:0] fill;

   always_comb begin
      fill       = wr_ptr - rd_ptr;
      due        = (fill >= STEP);
      rd_ptr_adv = rd_ptr + STEP;
   end

endmodule

// File: rtl/sdt_frame_gate.sv
module sdt_frame_gate #(
   parameter int OVR_W   = 8,
   parameter bit OVR_SAT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             walk_busy,
   input  logic             take,
   output logic             kick,
   output logic             pend,
   output logic             ovr_pulse,
   output logic [OVR_W-1:0] ovr_count
);

   if (OVR_W < 1) begin : g_bad_width
      $error("sdt_frame_gate: OVR_W must be at least 1");
   end

   logic hit;

   assign hit  = frame_start & (walk_busy | pend);
   assign kick = frame_start | pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         ovr_pulse <= 1'b0;
      end else begin
         pend      <= (pend & ~take) | hit;
         ovr_pulse <= hit;
      end
   end

   if (OVR_SAT) begin : g_sat_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)
            ovr_count <= '0;
         else if (hit && ovr_count != {OVR_W{1'b1}})
            ovr_count <= ovr_count + 1'b1;
      end
   end else begin : g_wrap_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)
            ovr_count <= '0;
         else if (hit)
            ovr_count <= ovr_count + 1'b1;
      end
   end

   // R9
   ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && walk_busy) |=> (ovr_pulse && pend));

   // R9
   ovr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_pulse && $past(ovr_count) != {OVR_W{1'b1}})
         |-> ovr_count == OVR_W'($past(ovr_count) + 1'b1));

endmodule

// File: rtl/sdt_seg_sched.sv
module sdt_seg_sched
   import sdt_sched_pkg::*;
#(
   parameter int AW       = 14,
   parameter int DW       = 16,
   parameter int PTR_W    = 8,
   parameter int PAYLOAD  = 47,
   parameter int TBL_LOG2 = 5,
   parameter int OVR_W    = 8,
   parameter bit OVR_SAT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic [PTR_W-1:0] wr_ptr,
   input  logic [AW-1:0]    tbl_base,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic [DW-1:0]    mem_rdata,
   output logic             cell_valid,
   input  logic             cell_ready,
   output logic [AW-1:0]    cell_addr,
   output logic             busy,
   output logic             ovr_pulse,
   output logic [OVR_W-1:0] ovr_count
);

   localparam int EN_BIT  = DW - 1;
   localparam int FIN_BIT = DW - 2;
   localparam int HI_W    = DW - PTR_W;
   localparam logic [TBL_LOG2-1:0] IDX_LAST = {TBL_LOG2{1'b1}};

   if (AW > DW - 2) begin : g_bad_aw
      $error("sdt_seg_sched: address must fit below the two entry flags");
   end
   if (PTR_W >= DW) begin : g_bad_ptr
      $error("sdt_seg_sched: read pointer must leave upper bits in word 0");
   end
   if (TBL_LOG2 < 1 || TBL_LOG2 >= AW) begin : g_bad_tbl
      $error("sdt_seg_sched: table index width out of range");
   end

   walk_state_t          st;
   logic [TBL_LOG2-1:0]  idx;
   logic [AW-1:0]        cs_addr;
   logic                 ent_fin;
   logic [PTR_W-1:0]     rp_q;
   logic [HI_W-1:0]      cs_hi;

   logic                 kick, pend, take, last;
   logic                 due;
   logic [PTR_W-1:0]     rp_adv;
   logic                 unused_base;

   assign unused_base = ^tbl_base[TBL_LOG2-1:0];

   sdt_due_calc #(
      .PTR_W   (PTR_W),
      .PAYLOAD (PAYLOAD)
   ) u_due (
      .rd_ptr     (rp_q),
      .wr_ptr     (wr_ptr),
      .due        (due),
      .rd_ptr_adv (rp_adv)
   );

   sdt_frame_gate #(
      .OVR_W   (OVR_W),
      .OVR_SAT (OVR_SAT)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .walk_busy   (busy),
      .take        (take),
      .kick        (kick),
      .pend        (pend),
      .ovr_pulse   (ovr_pulse),
      .ovr_count   (ovr_count)
   );

   assign busy = (st != ST_IDLE);
   assign last = ent_fin || (idx == IDX_LAST);
   assign take = ((st == ST_IDLE) && kick) || ((st == ST_NEXT) && last && pend);

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cs_addr;
      mem_wdata = {cs_hi, rp_adv};
      case (st)
         ST_ENT_RD: begin
            mem_req  = 1'b1;
            mem_addr = {tbl_base[AW-1:TBL_LOG2], idx};
         end
         ST_CS_RD: mem_req = 1'b1;
         ST_WB: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
         end
         default: ;
      endcase
   end

   assign cell_valid = (st == ST_REQ);
   assign cell_addr  = cs_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         idx     <= '0;
         cs_addr <= '0;
         ent_fin <= 1'b0;
         rp_q    <= '0;
         cs_hi   <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (kick) begin
                  st  <= ST_ENT_RD;
                  idx <= '0;
               end
            end
            ST_ENT_RD: st <= ST_ENT_CAP;
            ST_ENT_CAP: begin
               cs_addr <= mem_rdata[AW-1:0];
               ent_fin <= mem_rdata[FIN_BIT];
               st      <= mem_rdata[EN_BIT] ? ST_CS_RD : ST_NEXT;
            end
            ST_CS_RD: st <= ST_CS_CAP;
            ST_CS_CAP: begin
               rp_q  <= mem_rdata[PTR_W-1:0];
               cs_hi <= mem_rdata[DW-1:PTR_W];
               st    <= ST_CHK;
            end
            ST_CHK: st <= due ? ST_REQ : ST_NEXT;
            ST_REQ: begin
               if (cell_ready) st <= ST_WB;
            end
            ST_WB: st <= ST_NEXT;
            ST_NEXT: begin
               if (last) begin
                  if (pend) begin
                     st  <= ST_ENT_RD;
                     idx <= '0;
                  end else begin
                     st <= ST_IDLE;
                  end
               end else begin
                  idx <= idx + 1'b1;
                  st  <= ST_ENT_RD;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_valid && !cell_ready) |=> (cell_valid && $stable(cell_addr)));

   // R7
   wb_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(cell_valid && cell_ready));

   // R7
   wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !cell_valid));

endmodule

// File: tb/sdt_seg_sched_bench.sv
module sdt_seg_sched_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        frame_start;
   logic [7:0]  wr_ptr;
   logic [13:0] tbl_base;
   logic        mem_req, mem_we;
   logic [13:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        cell_valid;
   logic        cell_ready;
   logic [13:0] cell_addr;
   logic        busy, ovr_pulse;
   logic [7:0]  ovr_count;

   always #2 clk = ~clk;

   sdt_seg_sched u_sdt_seg_sched (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_ptr(wr_ptr),
      .tbl_base(tbl_base), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .cell_valid(cell_valid), .cell_ready(cell_ready), .cell_addr(cell_addr),
      .busy(busy), .ovr_pulse(ovr_pulse), .ovr_count(ovr_count)
   );

   logic [15:0] mem [0:1023];
   logic [15:0] sh  [0:1023];
   logic        cfg_we;
   logic [9:0]  cfg_a;
   logic [15:0] cfg_d;
   int          rdy_mode;
   int          rd_total, got_total, stall_seen, stall_err;
   logic [13:0] got [0:4095];
   logic        prev_stall;
   logic [13:0] prev_a;
   int          n_run, n_fail;
   bit          done;
   int          exp_n, exp_rd;
   logic [13:0] exp_addr [0:255];

   always @(posedge clk) begin
      if (cfg_we) mem[cfg_a] <= cfg_d;
      if (mem_req && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      if (mem_req && !mem_we) begin
         mem_rdata <= mem[mem_addr[9:0]];
         rd_total  = rd_total + 1;
      end
      if (cell_valid && cell_ready) begin
         got[got_total & 4095] = cell_addr;
         got_total = got_total + 1;
      end
      if (prev_stall) begin
         stall_seen = stall_seen + 1;
         if (!(cell_valid && cell_addr == prev_a)) stall_err = stall_err + 1;
      end
      prev_stall = cell_valid && !cell_ready;
      prev_a     = cell_addr;
   end

   always @(negedge clk) begin
      if (rdy_mode == 2)      cell_ready = 1'b0;
      else if (rdy_mode == 1) cell_ready = ($urandom % 3) != 0;
      else                    cell_ready = 1'b1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic poke(input int a, input logic [15:0] d);
      cfg_a = a[9:0]; cfg_d = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic logic [15:0] ent(input bit en, input bit fin, input int cs);
      return {en, fin, cs[13:0]};
   endfunction

   task automatic model_walk(input logic [7:0] wp);
      int base;
      base = {tbl_base[13:5], 5'b0};
      for (int i = 0; i < 32; i++) begin
         logic [15:0] e;
         e = sh[(base + i) & 1023];
         exp_rd++;
         if (e[15]) begin
            int cs;
            logic [7:0] rp;
            cs = e[9:0];
            exp_rd++;
            rp = sh[cs][7:0];
            if (8'(wp - rp) >= 8'd47) begin
               exp_addr[exp_n & 255] = e[13:0];
               exp_n++;
               sh[cs][7:0] = rp + 8'd47;
            end
         end
         if (e[14]) break;
      end
   endtask

   // runs one frame (nwalks=2 sends a second strobe during the walk)
   task automatic do_frame(input logic [7:0] wp, input int nwalks);
      int g0, r0, guard, mism, o0;
      for (int a = 0; a < 1024; a++) sh[a] = mem[a];
      exp_n = 0; exp_rd = 0;
      for (int w = 0; w < nwalks; w++) model_walk(wp);
      g0 = got_total; r0 = rd_total; o0 = ovr_count;
      wr_ptr = wp; frame_start = 1'b1;
      @(negedge clk);
      if (nwalks == 2) @(negedge clk);
      frame_start = 1'b0;
      guard = 0;
      while (busy && guard < 20000) begin @(negedge clk); guard++; end
      chk(guard < 20000, "R3", "walk ended", guard, 0);
      chk(got_total - g0 == exp_n, "R5/R6", "request count", got_total - g0, exp_n);
      for (int k = 0; k < exp_n && k < 256; k++)
         chk(got[(g0 + k) & 4095] == exp_addr[k], "R5", "request address",
             int'(got[(g0 + k) & 4095]), int'(exp_addr[k]));
      chk(rd_total - r0 == exp_rd, "R2/R3/R4", "memory reads", rd_total - r0, exp_rd);
      mism = 0;
      for (int a = 0; a < 1024; a++) if (mem[a] !== sh[a]) mism++;
      chk(mism == 0, "R7", "memory words differing", mism, 0);
      if (nwalks == 2)
         chk(int'(ovr_count) == o0 + 1, "R9", "overrun count", int'(ovr_count), o0 + 1);
   endtask

   initial begin
      n_run = 0; n_fail = 0; done = 0;
      rd_total = 0; got_total = 0; stall_seen = 0; stall_err = 0; prev_stall = 0;
      prev_a = '0;
      rst_n = 1'b0; frame_start = 1'b0; wr_ptr = '0; tbl_base = '0;
      rdy_mode = 0; cfg_we = 1'b0; cfg_a = '0; cfg_d = '0;
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(!busy && !cell_valid, "R1", "busy/valid after reset", busy + cell_valid, 0);
      chk(!mem_req && !mem_we && !ovr_pulse, "R1", "mem/ovr after reset",
          mem_req + mem_we + ovr_pulse, 0);
      chk(ovr_count == 0, "R1", "overrun count after reset", ovr_count, 0);
      rst_n = 1'b1;
      for (int a = 0; a < 1024; a++) poke(a, 16'h0000);

      // R2 R4 R5 R6 R3: unaligned base, disabled entry, final flag
      tbl_base = 14'h005A;
      poke(16'h040, ent(1, 0, 16'h200)); poke(16'h200, 16'hA500);
      poke(16'h041, ent(1, 0, 16'h204)); poke(16'h204, 16'hA50A);
      poke(16'h042, ent(0, 0, 16'h208)); poke(16'h208, 16'hA500);
      poke(16'h043, ent(1, 1, 16'h20C)); poke(16'h20C, 16'h5A00);
      poke(16'h044, ent(1, 0, 16'h210)); poke(16'h210, 16'h0000);
      poke(16'h05A, ent(1, 1, 16'h3F0)); poke(16'h3F0, 16'h0000);
      do_frame(8'd50, 1);
      chk(mem[10'h208] == 16'hA500, "R4", "disabled structure unchanged",
          mem[10'h208], 16'hA500);
      chk(mem[10'h20C] == 16'h5A2F, "R7", "advanced pointer upper bits kept",
          mem[10'h20C], 16'h5A2F);
      chk(mem[10'h210] == 16'h0000, "R3", "entry after final untouched",
          mem[10'h210], 0);

      // R3 entry-31 limit, R5/R6 boundary 46/47
      tbl_base = 14'h0080;
      for (int i = 0; i < 32; i++) begin
         poke(16'h080 + i, ent(1, 0, 16'h200 + 4 * i));
         poke(16'h200 + 4 * i, 16'h1100);
      end
      poke(16'h0A0, ent(1, 1, 16'h300)); poke(16'h300, 16'h0000);
      rdy_mode = 1;
      do_frame(8'd46, 1);
      chk(mem[10'h200] == 16'h1100, "R6", "diff 46 not advanced", mem[10'h200], 16'h1100);
      do_frame(8'd47, 1);
      chk(mem[10'h27C] == 16'h112F, "R5", "diff 47 advanced", mem[10'h27C], 16'h112F);
      chk(mem[10'h300] == 16'h0000, "R3", "entry 32 not used", mem[10'h300], 0);

      // R7 wrap of read pointer
      tbl_base = 14'h00C0;
      poke(16'h0C0, ent(1, 1, 16'h220)); poke(16'h220, 16'h33FA);
      do_frame(8'd41, 1);
      chk(mem[10'h220] == 16'h3329, "R7", "wrapped pointer", mem[10'h220], 16'h3329);

      // R9 overrun: second strobe during walk gives one extra walk
      poke(16'h220, 16'h0000);
      do_frame(8'd100, 2);
      chk(mem[10'h220] == 16'h005E, "R9", "two walks advanced twice", mem[10'h220], 16'h005E);

      // R8 stall: ready held low for a while
      poke(16'h220, 16'h0000);
      rdy_mode = 2;
      fork
         do_frame(8'd60, 1);
         begin repeat (40) @(negedge clk); rdy_mode = 0; end
      join
      chk(stall_seen > 20, "R8", "stall cycles observed", stall_seen, 21);
      chk(stall_err == 0, "R8", "request changed while stalled", stall_err, 0);

      // R10 staggered offsets spread the requests over frames
      tbl_base = 14'h0100;
      rdy_mode = 1;
      for (int i = 0; i < 32; i++) begin
         poke(16'h100 + i, ent(1, 0, 16'h200 + 4 * i));
         poke(16'h200 + 4 * i, 16'(i));
      end
      begin
         int g0, maxpf, gprev;
         g0 = got_total; maxpf = 0;
         for (int wp = 31; wp < 80; wp++) begin
            gprev = got_total;
            do_frame(8'(wp), 1);
            if (got_total - gprev > maxpf) maxpf = got_total - gprev;
         end
         chk(maxpf <= 1, "R10", "max requests in one frame", maxpf, 1);
         chk(got_total - g0 == 32, "R10", "requests over stagger run", got_total - g0, 32);
      end

      // R5 R6 R7 R8 random tables
      for (int f = 0; f < 40; f++) begin
         int n;
         tbl_base = 14'h0140 + 14'($urandom % 32);
         n = 1 + ($urandom % 32);
         for (int i = 0; i < 32; i++) begin
            int cs;
            bit en, fin;
            cs  = 16'h200 + 4 * ($urandom % 64);
            en  = ($urandom % 4) != 0;
            fin = (i == n - 1) && (($urandom % 4) != 0);
            poke(16'h140 + i, ent(en, fin, cs));
            poke(cs, 16'($urandom));
         end
         do_frame(8'($urandom), 1);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", 190000, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule